// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two WIDTH-bit operands and returns the full 2*WIDTH-bit product. It forms one partial product per clock cycle. In each step it looks at the lowest remaining bit of the multiplier. When that bit is 1 it adds the multiplicand into a running product. In the same cycle the multiplicand moves one place left and the multiplier moves one place right. A whole multiply therefore takes WIDTH cycles after it is accepted.

A mode input selects unsigned or two's-complement operands. In signed mode the block works on the operand magnitudes and fixes the sign when it writes the result. An accumulate enable makes the block return operand product plus a 2*WIDTH-bit addend, reduced modulo 2^(2*WIDTH).

The user pulses `start` while the block is idle. The user then waits for the one-cycle `done` pulse and reads `product`. That output keeps its value until the next multiply completes.

Top module: `mulShiftAdd`

## Requirements
- R1: After reset, `product` is 0 and `busy` and `done` are both low.
- R2: With `isSigned` low, `product` equals opA*opB as unsigned numbers over the full 2*WIDTH bits (for example 255*255 = 65025 at WIDTH 8).
- R3: With `isSigned` high, `product` is the two's-complement product over 2*WIDTH bits, including (-2^(WIDTH-1))*(-2^(WIDTH-1)) = 2^(2*WIDTH-2).
- R4: For the same operand bits, the low WIDTH bits of `product` are the same in signed and in unsigned mode.
- R5: With `accEn` high at start, `product` equals opA*opB + addend modulo 2^(2*WIDTH), in either mode. The mode decides how the operands are read, and `addend` is a 2*WIDTH-bit value.
- R6: A start accepted at a clock edge raises `busy` from the next cycle. `done` is high for exactly one cycle, WIDTH edges after the accepting edge, and `busy` falls on that same edge.
- R7: A `start` that arrives while `busy` is high is ignored. The running operation completes with its own operands, and no second operation follows.
- R8: `product` changes only on the edge where `done` rises. At all other times it holds its last value, whatever the inputs do.
- R9: 1000b * 1001b gives 1001000b (8*9 = 72) in unsigned mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiply; taken only while idle |
| isSigned | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| accEn | input | 1 | 1 = add `addend` to the product |
| opA | input | WIDTH | Multiplicand |
| opB | input | WIDTH | Multiplier |
| addend | input | 2*WIDTH | Value added when accumulating |
| busy | output | 1 | High while iterations run |
| done | output | 1 | One-cycle pulse when `product` is updated |
| product | output | 2*WIDTH | Result of the last completed multiply |

## Verification
Two events can fall on the same clock edge: the completion of a multiply, which raises `done`, drops `busy` and writes `product`, and a fresh `start`. The bench raises `start` on the cycle just after `done`. It also raises `start` in the middle of a run, where it must be ignored. A behavioural model predicts `busy`, `done` and `product` for every cycle. The bench compares the design against this model on every clock, so a second operation that begins early, late or twice shows up as a mismatch in the cycle where it happens.

// File: rtl/mulShiftAdd_pkg.sv
package mulShiftAdd_pkg;
  typedef struct packed {
    logic load;    // capture operands, clear/seed the running sum
    logic step;    // one add-and-shift iteration
    logic finish;  // last iteration: write the result
  } mulCtrl_t;
endpackage

// File: rtl/mulCtrl.sv
module mulCtrl
  import mulShiftAdd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output mulCtrl_t ctrl,
  output logic     busy,
  output logic     done
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] stepCnt;

  always_comb begin
    ctrl.load   = start && !busy;
    ctrl.step   = busy;
    ctrl.finish = busy && (stepCnt == CW'(WIDTH - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else begin
      done <= ctrl.finish;
      if (ctrl.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (ctrl.finish) begin
        busy    <= 1'b0;
      end else if (ctrl.step) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6: busy only ever ends together with done
  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R6: iteration count never passes the operand width
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (stepCnt < CW'(WIDTH)));
  // R7: an accepted start is followed by an iteration, never by a reload
  p_load_then_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (busy && !ctrl.load));
endmodule

// File: rtl/mulDatapath.sv
module mulDatapath
  import mulShiftAdd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulCtrl_t           ctrl,
  input  logic               isSigned,
  input  logic               accEn,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [2*WIDTH-1:0] addend,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    mcand;
  logic [WIDTH-1:0] mplr;
  logic [PW-1:0]    runSum;
  logic             negRes;

  logic             aNeg, bNeg, resNeg;
  logic [WIDTH-1:0] magA, magB;
  logic [PW-1:0]    seedVal, partial, nextSum;

  always_comb begin
    aNeg    = isSigned && opA[WIDTH-1];
    bNeg    = isSigned && opB[WIDTH-1];
    resNeg  = aNeg ^ bNeg;
    magA    = aNeg ? (~opA + 1'b1) : opA;
    magB    = bNeg ? (~opB + 1'b1) : opB;
    // the final negation also flips the addend, so pre-flip it here
    seedVal = accEn ? (resNeg ? (~addend + 1'b1) : addend) : '0;
    partial = mplr[0] ? mcand : '0;
    nextSum = runSum + partial;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand   <= '0;
      mplr    <= '0;
      runSum  <= '0;
      negRes  <= 1'b0;
      product <= '0;
    end else if (ctrl.load) begin
      mcand  <= {{WIDTH{1'b0}}, magA};
      mplr   <= magB;
      runSum <= seedVal;
      negRes <= resNeg;
    end else if (ctrl.step) begin
      runSum <= nextSum;
      mcand  <= mcand << 1;
      mplr   <= mplr >> 1;
      if (ctrl.finish)
        product <= negRes ? (~nextSum + 1'b1) : nextSum;
    end
  end

  // R2: by the last step every multiplier bit but the lowest is consumed
  p_mplr_drained_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.finish |-> ((mplr >> 1) == '0));
  // R8: the result moves only on a finishing step
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.finish |=> $stable(product));
endmodule

// File: rtl/mulShiftAdd.sv
module mulShiftAdd
  import mulShiftAdd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               isSigned,
  input  logic               accEn,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [2*WIDTH-1:0] addend,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  mulCtrl_t ctrl;

  mulCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  mulDatapath #(.WIDTH(WIDTH)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .isSigned (isSigned),
    .accEn    (accEn),
    .opA      (opA),
    .opB      (opB),
    .addend   (addend),
    .product  (product)
  );
endmodule

// File: tb/tb_mulShiftAdd.sv
module tb_mulShiftAdd;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0, isSigned = 1'b0, accEn = 1'b0;
  logic [W-1:0]  opA = '0, opB = '0;
  logic [PW-1:0] addend = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int    nCmp = 0, nBad = 0, cycles = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  mulShiftAdd #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .isSigned(isSigned),
    .accEn(accEn), .opA(opA), .opB(opB), .addend(addend),
    .busy(busy), .done(done), .product(product)
  );

  // behavioural reference model
  logic          mBusy = 1'b0, mDone = 1'b0;
  logic [PW-1:0] mProd = '0, mPend = '0;
  int            mLeft = 0;

  function automatic logic [PW-1:0] refVal(logic [W-1:0] a, logic [W-1:0] b,
                                           logic s, logic acc, logic [PW-1:0] add);
    longint x, y, r;
    x = s ? longint'($signed(a)) : longint'(a);
    y = s ? longint'($signed(b)) : longint'(b);
    r = x * y + (acc ? longint'(add) : 64'sd0);
    return r[PW-1:0];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy <= 1'b0; mDone <= 1'b0; mProd <= '0; mLeft <= 0;
    end else begin
      mDone <= 1'b0;
      if (!mBusy && start) begin
        mBusy <= 1'b1;
        mLeft <= W;
        mPend <= refVal(opA, opB, isSigned, accEn, addend);
      end else if (mBusy) begin
        mLeft <= mLeft - 1;
        if (mLeft == 1) begin
          mBusy <= 1'b0; mDone <= 1'b1; mProd <= mPend;
        end
      end
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check("R6", "busy", longint'(busy), longint'(mBusy));
      check("R6", "done", longint'(done), longint'(mDone));
      check((curReq == "R7") ? "R7" : "R8", "product", longint'(product), longint'(mProd));
    end
    if (cycles > 100000) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                       input logic acc, input logic [PW-1:0] add, input bit glitch,
                       output logic [PW-1:0] res);
    @(negedge clk);
    opA = a; opB = b; isSigned = s; accEn = acc; addend = add; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < W + 4 && !done; i++) begin
      if (glitch && i == 2) begin
        opA = ~a; opB = 8'h5a; start = 1'b1;   // R7: start while busy
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    res = product;
  endtask

  task automatic doMul(string req, logic [W-1:0] a, logic [W-1:0] b, logic s,
                       logic acc, logic [PW-1:0] add);
    logic [PW-1:0] r;
    curReq = req;
    runOp(a, b, s, acc, add, 1'b0, r);
    check(req, "result", longint'(r), longint'(refVal(a, b, s, acc, add)));
  endtask

  initial begin
    logic [PW-1:0] rU, rS, held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "busy", longint'(busy), 0);
    check("R1", "done", longint'(done), 0);
    check("R1", "product", longint'(product), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R9: 1000b * 1001b
    curReq = "R9";
    runOp(8'd8, 8'd9, 1'b0, 1'b0, '0, 1'b0, rU);
    check("R9", "1000x1001", longint'(rU), 72);

    // R2: unsigned patterns
    doMul("R2", 8'hff, 8'hff, 1'b0, 1'b0, '0);
    doMul("R2", 8'h00, 8'h7b, 1'b0, 1'b0, '0);
    doMul("R2", 8'h80, 8'h02, 1'b0, 1'b0, '0);
    doMul("R2", 8'h01, 8'hc3, 1'b0, 1'b0, '0);

    // R3: signed patterns
    doMul("R3", 8'h80, 8'h80, 1'b1, 1'b0, '0);
    doMul("R3", 8'h80, 8'h7f, 1'b1, 1'b0, '0);
    doMul("R3", 8'hff, 8'hff, 1'b1, 1'b0, '0);
    doMul("R3", 8'h05, 8'hfd, 1'b1, 1'b0, '0);
    doMul("R3", 8'hfd, 8'h00, 1'b1, 1'b0, '0);

    // R4: low half shared between modes
    curReq = "R4";
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] a, b;
      a = W'(37 * k + 129);
      b = W'(91 * k + 200);
      runOp(a, b, 1'b0, 1'b0, '0, 1'b0, rU);
      runOp(a, b, 1'b1, 1'b0, '0, 1'b0, rS);
      check("R4", "low half", longint'(rU[W-1:0]), longint'(rS[W-1:0]));
    end

    // R5: multiply-accumulate, both modes and wrap-around
    doMul("R5", 8'h0c, 8'h0d, 1'b0, 1'b1, 16'd1000);
    doMul("R5", 8'hff, 8'hff, 1'b0, 1'b1, 16'hffff);
    doMul("R5", 8'hfe, 8'h03, 1'b1, 1'b1, 16'd50);
    doMul("R5", 8'h80, 8'h80, 1'b1, 1'b1, 16'hc000);
    doMul("R5", 8'h07, 8'hf9, 1'b1, 1'b1, 16'h8000);

    // R7: start pulse mid-run is ignored
    curReq = "R7";
    runOp(8'h13, 8'h21, 1'b0, 1'b0, '0, 1'b1, rU);
    check("R7", "first op kept", longint'(rU), longint'(refVal(8'h13, 8'h21, 1'b0, 1'b0, '0)));

    // R6: restart on the cycle right after done (back-to-back)
    curReq = "R6";
    runOp(8'h11, 8'h11, 1'b0, 1'b0, '0, 1'b0, rU);
    runOp(8'h22, 8'h03, 1'b0, 1'b0, '0, 1'b0, rU);
    check("R6", "back-to-back", longint'(rU), 102);

    // R8: result holds while inputs move without start
    curReq = "R8";
    held = product;
    for (int k = 0; k < 5; k++) begin
      opA = W'(k * 17); opB = W'(k * 29); isSigned = k[0]; accEn = k[1];
      @(negedge clk);
    end
    check("R8", "held product", longint'(product), longint'(held));

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule